// File: doc/BRIEF.md
# TFT Panel Row and Frame Strobe Generator

This block drives the row and frame control strobes of a portrait TFT panel with 240 columns and 320 visible rows, all from one pixel-clock domain. It produces five periodic pulse trains: a one-clock row latch, a frame start that spans two rows, a one-clock sample strobe, an active-low shift/clear window at the start of every row, and a polarity reversal signal that flips once per row. Each train comes from its own counter with a programmable width and period.

The row length in pixel clocks and the number of rows per frame are inputs. For a frame rate of 60 Hz with 329 rows per frame (320 shown, 9 blanking), the row length is the pixel-clock rate divided by 60 and then by 329; at 6 MHz that truncates to 303 clocks. When `enable` rises, a start sequencer brings the trains up in a fixed order. The reversal counter starts first. The row latch starts once the reversal count has passed a threshold. The remaining three start together once the latch count has reached a second threshold. Dropping `enable` stops every counter at once, so the row length and frame size can be changed safely before the block is enabled again.

Top module: `tft_strobe_gen`

## Requirements
- R1: After reset, and while idle, `row_latch`, `frame_start` and `sample` are 0, `shift_win_n` is 1, `pol_rev` is 0 and `start_done` is 0.
- R2: The reversal counter starts at the first clock edge that samples `enable` high (edge 0). After edge k, `pol_rev` is 1 when (k mod 2L) < L, where L is `line_len`.
- R3: The row latch counter is released at edge 13, the first edge after the reversal count has exceeded REV_GATE = 11. After edge k ≥ 13, `row_latch` is 1 exactly when (k−13) mod L = 0.
- R4: Sample, frame start and shift/clear start together at edge 17, the first edge after the latch count has reached LINE_GATE = 3. After edge k ≥ 17, `sample` is 1 exactly when (k−17) mod L = 0.
- R5: After edge k ≥ 17, `frame_start` is 1 when (k−17) mod (L·F) < 2L, where F is `frame_lines`.
- R6: After edge k ≥ 17, `shift_win_n` is 0 when (k−17) mod L < SHIFT_WIDTH, and 1 otherwise. The default SHIFT_WIDTH is 248.
- R7: `start_done` is 0 before edge 17 and 1 from edge 17 on, for as long as `enable` stays high.
- R8: After the first edge that samples `enable` low, every output is back at its R1 value. The next rise of `enable` restarts the whole sequence from edge 0, using the `line_len` and `frame_lines` values present at that time.
- R9: The values supplied must satisfy `line_len` ≥ 7 and `frame_lines` ≥ 3. Under that condition, every counter stays below its own period while it runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the strobe generators; when low, all counters are cleared |
| line_len | input | LINE_W | Row period in pixel clocks (L) |
| frame_lines | input | FLINE_W | Rows per frame (F) |
| row_latch | output | 1 | One-clock row latch strobe |
| frame_start | output | 1 | Frame start pulse, two rows wide |
| sample | output | 1 | One-clock sample strobe |
| shift_win_n | output | 1 | Active-low shift/clear window |
| pol_rev | output | 1 | Polarity reversal, alternating each row |
| start_done | output | 1 | High once every generator is running |

## Verification
The bench builds the block with LINE_W = 8, FLINE_W = 6 and SHIFT_WIDTH = 5. This shrinks a frame to a few dozen to a couple of hundred clocks. As a result, every output can be compared against its closed-form expectation on every cycle across two full frames for several row lengths, including the shortest row length the start thresholds allow. The same small setup also reaches a mid-start disable and a reconfigure-then-restart within a few hundred cycles.

// File: rtl/tft_strobe_pkg.sv
package tft_strobe_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_REV  = 2'd1,
    SQ_LINE = 2'd2,
    SQ_ALL  = 2'd3
  } seq_state_e;
endpackage

// File: rtl/strobe_pulse.sv
module strobe_pulse #(
  parameter int W           = 14,
  parameter bit ACTIVE_HIGH = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic [W-1:0] width,
  input  logic [W-1:0] period,
  output logic [W-1:0] cnt,
  output logic         pulse
);
  logic [W-1:0] cnt_nxt;
  logic         in_window;

  always_comb begin
    if (!run)
      cnt_nxt = '0;
    else if (cnt >= period - W'(1))
      cnt_nxt = '0;
    else
      cnt_nxt = cnt + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_nxt;
  end

  assign in_window = run && (cnt < width);

  generate
    if (ACTIVE_HIGH) begin : g_hi
      assign pulse = in_window;
    end else begin : g_lo
      assign pulse = !in_window;
    end
  endgenerate

  // R9: a running counter never reaches its period
  p_cnt_in_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt < period));

  // R8: a nonzero count exists only if the generator ran on the previous edge
  p_cnt_origin_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0) |-> $past(run));
endmodule

// File: rtl/tft_start_seq.sv
module tft_start_seq
  import tft_strobe_pkg::*;
#(
  parameter int W         = 14,
  parameter int REV_GATE  = 11,
  parameter int LINE_GATE = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         enable,
  input  logic [W-1:0] rev_cnt,
  input  logic [W-1:0] line_cnt,
  output logic         run_rev,
  output logic         run_line,
  output logic         run_all,
  output logic         done
);
  seq_state_e state, state_nxt;

  always_comb begin
    state_nxt = state;
    if (!enable) begin
      state_nxt = SQ_IDLE;
    end else begin
      case (state)
        SQ_IDLE: state_nxt = SQ_REV;
        SQ_REV:  if (rev_cnt > W'(REV_GATE))    state_nxt = SQ_LINE;
        SQ_LINE: if (line_cnt >= W'(LINE_GATE)) state_nxt = SQ_ALL;
        default: state_nxt = state;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= SQ_IDLE;
    else        state <= state_nxt;
  end

  assign run_rev  = enable && (state != SQ_IDLE);
  assign run_line = enable && ((state == SQ_LINE) || (state == SQ_ALL));
  assign run_all  = enable && (state == SQ_ALL);
  assign done     = (state == SQ_ALL);

  // R3: latch generator released only after reversal count passed its gate
  p_line_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_line) |-> ($past(rev_cnt) > W'(REV_GATE)));

  // R4: remaining generators released only after latch count reached its gate
  p_all_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_all) |-> ($past(line_cnt) >= W'(LINE_GATE)));
endmodule

// File: rtl/tft_strobe_gen.sv
module tft_strobe_gen #(
  parameter int LINE_W      = 10,
  parameter int FLINE_W     = 9,
  parameter int SHIFT_WIDTH = 248,
  parameter int REV_GATE    = 11,
  parameter int LINE_GATE   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic [LINE_W-1:0]  line_len,
  input  logic [FLINE_W-1:0] frame_lines,
  output logic               row_latch,
  output logic               frame_start,
  output logic               sample,
  output logic               shift_win_n,
  output logic               pol_rev,
  output logic               start_done
);
  localparam int W = LINE_W + FLINE_W;

  logic [W-1:0] len_w, len2_w, frame_per, one_w, shift_w;
  logic [W-1:0] rev_cnt, line_cnt, samp_cnt, frm_cnt, shf_cnt;
  logic         run_rev, run_line, run_all;

  assign len_w     = W'(line_len);
  assign len2_w    = len_w << 1;
  assign frame_per = len_w * W'(frame_lines);
  assign one_w     = W'(1);
  assign shift_w   = W'(SHIFT_WIDTH);

  tft_start_seq #(.W(W), .REV_GATE(REV_GATE), .LINE_GATE(LINE_GATE)) u_seq (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .rev_cnt(rev_cnt), .line_cnt(line_cnt),
    .run_rev(run_rev), .run_line(run_line), .run_all(run_all),
    .done(start_done)
  );

  strobe_pulse #(.W(W), .ACTIVE_HIGH(1'b1)) u_rev (
    .clk(clk), .rst_n(rst_n), .run(run_rev),
    .width(len_w), .period(len2_w), .cnt(rev_cnt), .pulse(pol_rev)
  );

  strobe_pulse #(.W(W), .ACTIVE_HIGH(1'b1)) u_latch (
    .clk(clk), .rst_n(rst_n), .run(run_line),
    .width(one_w), .period(len_w), .cnt(line_cnt), .pulse(row_latch)
  );

  strobe_pulse #(.W(W), .ACTIVE_HIGH(1'b1)) u_sample (
    .clk(clk), .rst_n(rst_n), .run(run_all),
    .width(one_w), .period(len_w), .cnt(samp_cnt), .pulse(sample)
  );

  strobe_pulse #(.W(W), .ACTIVE_HIGH(1'b1)) u_frame (
    .clk(clk), .rst_n(rst_n), .run(run_all),
    .width(len2_w), .period(frame_per), .cnt(frm_cnt), .pulse(frame_start)
  );

  strobe_pulse #(.W(W), .ACTIVE_HIGH(1'b0)) u_shift (
    .clk(clk), .rst_n(rst_n), .run(run_all),
    .width(shift_w), .period(len_w), .cnt(shf_cnt), .pulse(shift_win_n)
  );

  // R3: the row latch is one clock wide
  p_latch_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    row_latch |=> !row_latch);

  // R4: the three late generators come up on the same edge as done
  p_start_together_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(start_done) |-> (sample && frame_start && !shift_win_n));

  // R8: a low enable leaves everything idle after the next edge
  p_disable_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!start_done && !pol_rev && !row_latch));
endmodule

// File: tb/tb_tft_strobe_gen.sv
module tb_tft_strobe_gen;
  localparam int LINE_W  = 8;
  localparam int FLINE_W = 6;
  localparam int SW      = 5;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               enable = 1'b0;
  logic [LINE_W-1:0]  line_len = '0;
  logic [FLINE_W-1:0] frame_lines = '0;
  logic row_latch, frame_start, sample, shift_win_n, pol_rev, start_done;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  tft_strobe_gen #(.LINE_W(LINE_W), .FLINE_W(FLINE_W), .SHIFT_WIDTH(SW)) dut (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .line_len(line_len), .frame_lines(frame_lines),
    .row_latch(row_latch), .frame_start(frame_start), .sample(sample),
    .shift_win_n(shift_win_n), .pol_rev(pol_rev), .start_done(start_done)
  );

  task automatic chk(input string req, input string what, input logic got,
                     input logic exp, input int k);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s at k=%0d: actual %b expected %b", req, what, k, got, exp);
    end
  endtask

  task automatic chk_idle(input string req);
    chk(req, "row_latch",   row_latch,   1'b0, -1);
    chk(req, "frame_start", frame_start, 1'b0, -1);
    chk(req, "sample",      sample,      1'b0, -1);
    chk(req, "shift_win_n", shift_win_n, 1'b1, -1);
    chk(req, "pol_rev",     pol_rev,     1'b0, -1);
    chk(req, "start_done",  start_done,  1'b0, -1);
  endtask

  // enable at a negedge, then compare every cycle against closed forms
  task automatic run_cfg(input int L, input int F, input int cycles);
    line_len    = LINE_W'(L);
    frame_lines = FLINE_W'(F);
    enable      = 1'b1;
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk);
      chk("R2", "pol_rev", pol_rev, logic'((k % (2*L)) < L), k);
      chk("R3", "row_latch", row_latch, logic'(k >= 13 && ((k-13) % L) == 0), k);
      chk("R4", "sample", sample, logic'(k >= 17 && ((k-17) % L) == 0), k);
      chk("R5", "frame_start", frame_start,
          logic'(k >= 17 && ((k-17) % (L*F)) < 2*L), k);
      chk("R6", "shift_win_n", shift_win_n,
          logic'(!(k >= 17 && ((k-17) % L) < SW)), k);
      chk("R7", "start_done", start_done, logic'(k >= 17), k);
    end
  endtask

  task automatic stop_and_check();
    enable = 1'b0;
    @(negedge clk);
    chk_idle("R8");
    @(negedge clk);
    chk_idle("R8");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk_idle("R1");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_idle("R1");

    run_cfg(16, 5, 17 + 2*16*5 + 5);
    stop_and_check();
    run_cfg(9, 4, 17 + 2*9*4 + 5);
    stop_and_check();
    // shortest row allowed by the start thresholds (R9)
    run_cfg(7, 3, 17 + 2*7*3 + 5);
    stop_and_check();
    // disable in the middle of the start sequence, then restart fresh (R8)
    run_cfg(12, 3, 15);
    stop_and_check();
    run_cfg(10, 4, 17 + 2*10*4 + 5);
    stop_and_check();

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule